// File: doc/BRIEF.md
# SPI Master Chip-Select and Mode-Fault Controller

This block is the control core of an SPI master. It decides which of four active-low slave-select lines to pull low for each transfer, runs a small 8-bit shift engine (SCK, MOSI, MISO) and watches a slave-select input for a second master on the bus. Software reaches it through a small register port with write and read strobes, a 4-bit address and 32-bit data.

The select code has one of two sources. In fixed mode it comes from a field in the mode register. In variable mode it comes from a field written together with each transmit byte. The code is used in one of two ways. In direct mode it picks one of the four lines itself. In decoded mode it goes to the pins unchanged, so that an external decoder can address up to 15 slaves. Each of the four peripheral configuration registers sets its own SCK half-period and bit count. If another master pulls the slave-select input low, the block latches a fault, stops the transfer and stays disabled until software enables it again.

Register map (address: contents):
- 0 CTRL (write): bit 0 enables, bit 1 disables.
- 1 MODE: bit 0 master, bit 1 variable select, bit 2 decoded, bits [7:4] select code.
- 2 STATUS (read): bit 0 fault, bit 1 busy, bit 2 receive full, bit 3 enabled.
- 3 TXD (write): [7:0] data, [19:16] select code.
- 4 RXD (read): [7:0] data, [19:16] select pattern.
- 8+k CFGk: [7:0] half-period, [18:16] bit count minus one.

Top module: `spi_cs_master`

## Requirements
- R1: After reset cs_n is 4'hF, sck is 0, STATUS reads 0 and the block is disabled.
- R2: With MODE[1]=0 (fixed) the select code is MODE[7:4], and TXD[19:16] has no effect.
- R3: With MODE[1]=1 (variable) the select code is TXD[19:16] of each write, and MODE[7:4] has no effect.
- R4: With MODE[2]=0 (direct) only cs_n[i] is driven low, where i is the lowest zero bit of the code. A code of 4'hF starts no transfer.
- R5: With MODE[2]=1 (decoded) the 4-bit code is driven as is onto cs_n[3:0]. A code of 4'hF starts no transfer.
- R6: A transfer uses CFGk. In direct mode k is the lowest zero bit index of the code; in decoded mode k is code[1:0]. With H = CFGk[7:0] (0 counts as 1) and N = CFGk[18:16]+1, the block sends the low N bits of TXD[7:0] MSB first, samples MISO at each SCK rise, raises SCK N times and holds the select low for H*(2N+1) clock cycles.
- R7: cs_n is 4'hF whenever no transfer runs, and it stays constant during a transfer. A write to MODE[7:4] during a transfer applies only from the next transfer on.
- R8: At the end of a transfer RXD[7:0] holds the received bits, right-aligned, and RXD[19:16] holds the select pattern that was driven. STATUS[2] is then set, and it is cleared by a read of RXD.
- R9: With MODE[0]=0 no transfer starts, cs_n stays 4'hF and nss_n is ignored.
- R10: In master mode with the block enabled, nss_n low (after a two-flop synchronizer) sets STATUS[0], clears STATUS[3] and aborts any transfer: cs_n goes to 4'hF and sck to 0.
- R11: STATUS[0] stays set until STATUS is read. STATUS[3] stays 0 until a CTRL write with bit 0 set.
- R12: A TXD write while the block is disabled or busy is discarded: no busy flag, no change on cs_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears on-read flags) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out, MSB first |
| miso | input | 1 | Serial data in, sampled at SCK rise |
| cs_n | output | 4 | Active-low slave selects |
| nss_n | input | 1 | Slave-select input watched for contention |

## Verification
The embedded assertions check several things on every cycle. The select lines stay fixed while a transfer runs and are all high when the engine is idle. SCK rises only while a select is asserted. A direct-mode start drives exactly one line low. No transfer begins while the block is disabled or not in master mode. A latched fault clears the enable and is not lost before a status read. Only the bench scenarios can show the rest. These are the choice between the two code sources and the two encodings, the configuration picked per peripheral, the exact select width in cycles and the SCK edge count, the serial data in both directions, the captured pattern in RXD, and the deferred effect of a MODE write made during a transfer.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  localparam int unsigned NCS = 4;

  localparam logic [3:0] ADDR_CTRL     = 4'd0;
  localparam logic [3:0] ADDR_MODE     = 4'd1;
  localparam logic [3:0] ADDR_STAT     = 4'd2;
  localparam logic [3:0] ADDR_TXD      = 4'd3;
  localparam logic [3:0] ADDR_RXD      = 4'd4;
  localparam logic [3:0] ADDR_CFG_BASE = 4'd8;

  localparam int unsigned MODE_PCS_LSB = 4;
  localparam int unsigned TX_PCS_LSB   = 16;
  localparam int unsigned CFG_CNT_LSB  = 16;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_LEAD = 2'd1,
    ENG_HIGH = 2'd2,
    ENG_LOW  = 2'd3
  } eng_state_e;
endpackage

// File: rtl/spi_cs_select.sv
module spi_cs_select
  import spi_cs_pkg::*;
#(
  parameter int unsigned IDX_W = $clog2(NCS)
) (
  input  logic             var_sel,
  input  logic             decode,
  input  logic [NCS-1:0]   mode_pcs,
  input  logic [NCS-1:0]   tx_pcs,
  output logic [NCS-1:0]   lines,
  output logic [IDX_W-1:0] cfg_idx,
  output logic             valid
);
  logic [NCS-1:0]   code;
  logic [IDX_W-1:0] low_zero;
  logic             found;

  always_comb begin
    code     = var_sel ? tx_pcs : mode_pcs;
    low_zero = '0;
    found    = 1'b0;
    for (int i = 0; i < NCS; i++) begin
      if (!found && !code[i]) begin
        low_zero = IDX_W'(i);
        found    = 1'b1;
      end
    end
    valid = found;
    if (!found)
      lines = '1;
    else if (decode)
      lines = code;
    else
      lines = ~(NCS'(1) << low_zero);
    cfg_idx = decode ? code[IDX_W-1:0] : low_zero;
  end
endmodule

// File: rtl/spi_cs_engine.sv
module spi_cs_engine
  import spi_cs_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [NCS-1:0]    lines,
  input  logic [DIV_W-1:0]  half_div,
  input  logic [CNT_W-1:0]  bits_m1,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic [NCS-1:0]    cs_q,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_data
);
  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DATA_W - 1);

  eng_state_e        st_q, st_d;
  logic [DIV_W-1:0]  cnt_q, cnt_d, half_q, half_d, eff_half;
  logic [CNT_W-1:0]  left_q, left_d;
  logic [DATA_W-1:0] sh_q, sh_d, rx_q, rx_d;
  logic [NCS-1:0]    cs_d;
  logic              sck_q, sck_d, tick;

  assign eff_half = (half_div == '0) ? DIV_ONE : half_div;
  assign tick     = (cnt_q == '0);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    half_d = half_q;
    left_d = left_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    sck_d  = sck_q;
    cs_d   = cs_q;
    done   = 1'b0;
    unique case (st_q)
      ENG_IDLE: begin
        if (start) begin
          st_d   = ENG_LEAD;
          cs_d   = lines;
          sh_d   = tx_data << (CNT_TOP - bits_m1);
          rx_d   = '0;
          left_d = bits_m1;
          half_d = eff_half;
          cnt_d  = eff_half - DIV_ONE;
        end
      end
      ENG_LEAD: begin
        if (tick) begin
          st_d  = ENG_HIGH;
          sck_d = 1'b1;
          rx_d  = {rx_q[DATA_W-2:0], miso};
          cnt_d = half_q - DIV_ONE;
        end else begin
          cnt_d = cnt_q - DIV_ONE;
        end
      end
      ENG_HIGH: begin
        if (tick) begin
          st_d  = ENG_LOW;
          sck_d = 1'b0;
          sh_d  = {sh_q[DATA_W-2:0], 1'b0};
          cnt_d = half_q - DIV_ONE;
        end else begin
          cnt_d = cnt_q - DIV_ONE;
        end
      end
      ENG_LOW: begin
        if (tick) begin
          if (left_q == '0) begin
            st_d = ENG_IDLE;
            cs_d = '1;
            done = 1'b1;
          end else begin
            st_d   = ENG_HIGH;
            left_d = left_q - CNT_ONE;
            sck_d  = 1'b1;
            rx_d   = {rx_q[DATA_W-2:0], miso};
            cnt_d  = half_q - DIV_ONE;
          end
        end else begin
          cnt_d = cnt_q - DIV_ONE;
        end
      end
      default: st_d = ENG_IDLE;
    endcase
    if (abort) begin
      st_d  = ENG_IDLE;
      sck_d = 1'b0;
      cs_d  = '1;
      done  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      cnt_q  <= '0;
      half_q <= DIV_ONE;
      left_q <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      sck_q  <= 1'b0;
      cs_q   <= '1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      half_q <= half_d;
      left_q <= left_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      sck_q  <= sck_d;
      cs_q   <= cs_d;
    end
  end

  assign sck     = sck_q;
  assign mosi    = sh_q[DATA_W-1];
  assign busy    = (st_q != ENG_IDLE);
  assign rx_data = rx_q;

  // R7: the select pattern holds for the whole transfer
  a_r7_cs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cs_q));
  // R6: every SCK rise falls inside an asserted select window
  a_r6_sck_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> (busy && cs_q != '1));
endmodule

// File: rtl/spi_cs_regs.sv
module spi_cs_regs
  import spi_cs_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned CNT_W  = $clog2(DATA_W),
  parameter int unsigned IDX_W  = $clog2(NCS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [3:0]                  bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  input  logic                        nss_n,
  input  logic                        busy,
  input  logic                        done,
  input  logic                        sel_valid,
  input  logic [NCS-1:0]              eng_cs,
  input  logic [DATA_W-1:0]           eng_rx,
  output logic                        start,
  output logic                        en,
  output logic                        master,
  output logic                        var_sel,
  output logic                        decode,
  output logic [NCS-1:0]              mode_pcs,
  output logic [NCS-1:0][DIV_W-1:0]   cfg_div,
  output logic [NCS-1:0][CNT_W-1:0]   cfg_cnt
);
  logic                      en_q, en_d, modf_q, modf_d, full_q, full_d;
  logic                      nss_s1, nss_s2, fault;
  logic [2:0]                mflags_q, mflags_d;
  logic [NCS-1:0]            mpcs_q, mpcs_d;
  logic [NCS-1:0]            rx_cs_q, rx_cs_d;
  logic [DATA_W-1:0]         rx_q, rx_d;
  logic [NCS-1:0][DIV_W-1:0] div_q, div_d;
  logic [NCS-1:0][CNT_W-1:0] cnt_q, cnt_d;
  logic [NCS-1:0]            cfg_hit;
  logic [3:0]                cfg_off;
  logic                      wr_ctrl, wr_mode, wr_tx, rd_stat, rd_rx;
  logic                      wdata_unused;

  assign wr_ctrl      = bus_wr && bus_addr == ADDR_CTRL;
  assign wr_mode      = bus_wr && bus_addr == ADDR_MODE;
  assign wr_tx        = bus_wr && bus_addr == ADDR_TXD;
  assign rd_stat      = bus_rd && bus_addr == ADDR_STAT;
  assign rd_rx        = bus_rd && bus_addr == ADDR_RXD;
  assign wdata_unused = ^bus_wdata;

  for (genvar g = 0; g < NCS; g++) begin : g_cfg_hit
    assign cfg_hit[g] = bus_wr && bus_addr == (ADDR_CFG_BASE + 4'(g));
  end

  assign master   = mflags_q[0];
  assign var_sel  = mflags_q[1];
  assign decode   = mflags_q[2];
  assign mode_pcs = mpcs_q;
  assign en       = en_q;
  assign cfg_div  = div_q;
  assign cfg_cnt  = cnt_q;
  assign fault    = master && en_q && !nss_s2;
  assign start    = wr_tx && en_q && master && !busy && sel_valid;

  always_comb begin
    en_d     = en_q;
    modf_d   = modf_q;
    full_d   = full_q;
    mflags_d = mflags_q;
    mpcs_d   = mpcs_q;
    rx_d     = rx_q;
    rx_cs_d  = rx_cs_q;
    div_d    = div_q;
    cnt_d    = cnt_q;
    if (wr_ctrl) begin
      if (bus_wdata[1])      en_d = 1'b0;
      else if (bus_wdata[0]) en_d = 1'b1;
    end
    if (fault) en_d = 1'b0;
    if (fault)        modf_d = 1'b1;
    else if (rd_stat) modf_d = 1'b0;
    if (done) begin
      full_d  = 1'b1;
      rx_d    = eng_rx;
      rx_cs_d = eng_cs;
    end else if (rd_rx) begin
      full_d = 1'b0;
    end
    if (wr_mode) begin
      mflags_d = bus_wdata[2:0];
      mpcs_d   = bus_wdata[MODE_PCS_LSB +: NCS];
    end
    for (int i = 0; i < NCS; i++) begin
      if (cfg_hit[i]) begin
        div_d[i] = bus_wdata[DIV_W-1:0];
        cnt_d[i] = bus_wdata[CFG_CNT_LSB +: CNT_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      modf_q   <= 1'b0;
      full_q   <= 1'b0;
      mflags_q <= '0;
      mpcs_q   <= '1;
      rx_q     <= '0;
      rx_cs_q  <= '1;
      div_q    <= '0;
      cnt_q    <= '1;
      nss_s1   <= 1'b1;
      nss_s2   <= 1'b1;
    end else begin
      en_q     <= en_d;
      modf_q   <= modf_d;
      full_q   <= full_d;
      mflags_q <= mflags_d;
      mpcs_q   <= mpcs_d;
      rx_q     <= rx_d;
      rx_cs_q  <= rx_cs_d;
      div_q    <= div_d;
      cnt_q    <= cnt_d;
      nss_s1   <= nss_n;
      nss_s2   <= nss_s1;
    end
  end

  assign cfg_off = bus_addr - ADDR_CFG_BASE;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_MODE: begin
        bus_rdata[2:0] = mflags_q;
        bus_rdata[MODE_PCS_LSB +: NCS] = mpcs_q;
      end
      ADDR_STAT: bus_rdata[3:0] = {en_q, full_q, busy, modf_q};
      ADDR_RXD: begin
        bus_rdata[DATA_W-1:0] = rx_q;
        bus_rdata[TX_PCS_LSB +: NCS] = rx_cs_q;
      end
      default: begin
        if (cfg_off < 4'(NCS)) begin
          bus_rdata[DIV_W-1:0] = div_q[cfg_off[IDX_W-1:0]];
          bus_rdata[CFG_CNT_LSB +: CNT_W] = cnt_q[cfg_off[IDX_W-1:0]];
        end
      end
    endcase
  end

  // R10: a newly latched fault always comes with the enable dropped
  a_r10_fault_disables: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf_q) |-> !en_q);
  // R11: the fault flag survives until a status read
  a_r11_modf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(modf_q) && !$past(rd_stat)) |-> modf_q);
  // R11: enable only returns through a control write
  a_r11_reenable_by_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(wr_ctrl));
endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
  import spi_cs_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  cs_n,
  input  logic        nss_n
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam int unsigned IDX_W = $clog2(NCS);

  logic                      start, en, master, var_sel, decode;
  logic                      busy, done, sel_valid, abort;
  logic [NCS-1:0]            mode_pcs, sel_lines, eng_cs;
  logic [IDX_W-1:0]          sel_idx;
  logic [DATA_W-1:0]         eng_rx;
  logic [NCS-1:0][DIV_W-1:0] cfg_div;
  logic [NCS-1:0][CNT_W-1:0] cfg_cnt;

  spi_cs_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .nss_n(nss_n), .busy(busy), .done(done), .sel_valid(sel_valid),
    .eng_cs(eng_cs), .eng_rx(eng_rx), .start(start), .en(en),
    .master(master), .var_sel(var_sel), .decode(decode),
    .mode_pcs(mode_pcs), .cfg_div(cfg_div), .cfg_cnt(cfg_cnt)
  );

  spi_cs_select #(.IDX_W(IDX_W)) u_sel (
    .var_sel(var_sel), .decode(decode), .mode_pcs(mode_pcs),
    .tx_pcs(bus_wdata[TX_PCS_LSB +: NCS]), .lines(sel_lines),
    .cfg_idx(sel_idx), .valid(sel_valid)
  );

  assign abort = !(en && master);

  spi_cs_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .tx_data(bus_wdata[DATA_W-1:0]), .lines(sel_lines),
    .half_div(cfg_div[sel_idx]), .bits_m1(cfg_cnt[sel_idx]),
    .miso(miso), .sck(sck), .mosi(mosi), .cs_q(eng_cs),
    .busy(busy), .done(done), .rx_data(eng_rx)
  );

  assign cs_n = master ? eng_cs : '1;

  // R7: no line low while the engine is idle
  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n == '1);
  // R12 / R9: a transfer begins only when enabled in master mode
  a_r12_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en && master));
  // R4: a direct-mode start pulls exactly one line low
  a_r4_direct_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !$past(decode)) |-> $countones(~cs_n) == 1);
endmodule

// File: tb/sim_spi_cs_master.sv
`timescale 1ns/1ps
module sim_spi_cs_master;
  logic        clk, rst_n, wr, rd, miso, nss_n;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  logic        sck, mosi;
  logic [3:0]  cs_n;

  int checks = 0;
  int fails  = 0;

  spi_cs_master u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_n(cs_n), .nss_n(nss_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // slave model and window monitor
  int          cur_n = 8;
  logic [7:0]  cur_pat = 8'h00;
  int          rise_total = 0, rise_base = 0;
  int          cyc_total = 0, chg_total = 0;
  logic [7:0]  mosi_cap = 8'h00;
  logic [3:0]  last_cs = 4'hF;
  logic        in_xfer = 1'b0;

  always @(posedge sck) begin
    mosi_cap = {mosi_cap[6:0], mosi};
    rise_total++;
  end

  always @* begin
    int k;
    k = cur_n - 1 - (rise_total - rise_base);
    miso = (k >= 0 && k < 8) ? cur_pat[k] : 1'b0;
  end

  always @(posedge clk) begin
    if (cs_n != 4'hF) begin
      cyc_total++;
      if (in_xfer && cs_n != last_cs) chg_total++;
      last_cs = cs_n;
      in_xfer = 1'b1;
    end else begin
      in_xfer = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_idle();
    while (cs_n != 4'hF) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] mode_word(logic vs, logic dc, logic [3:0] p, logic m);
    return {24'h0, p, 1'b0, dc, vs, m};
  endfunction

  typedef struct packed {
    logic       vsel;
    logic       dec;
    logic [3:0] mpcs;
    logic [3:0] tpcs;
    logic [7:0] data;
    logic [7:0] pat;
    logic [3:0] ecs;
    logic [7:0] eh;
    logic [3:0] en;
  } vec_t;

  // CFG0: H1 N8, CFG1: H2 N8, CFG2: H0->1 N4, CFG3: H3 N5
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 4'hE, 4'h0, 8'hA5, 8'h3C, 4'hE, 8'd1, 4'd8},
    '{1'b0, 1'b0, 4'hD, 4'hF, 8'h0F, 8'hC3, 4'hD, 8'd2, 4'd8},
    '{1'b1, 1'b0, 4'hE, 4'hB, 8'h0D, 8'h09, 4'hB, 8'd1, 4'd4},
    '{1'b1, 1'b0, 4'hE, 4'h7, 8'h13, 8'h16, 4'h7, 8'd3, 4'd5},
    '{1'b1, 1'b0, 4'h7, 4'hA, 8'hFF, 8'h00, 4'hE, 8'd1, 4'd8},
    '{1'b0, 1'b1, 4'h6, 4'h1, 8'h81, 8'h7E, 4'h6, 8'd1, 4'd4},
    '{1'b1, 1'b1, 4'h0, 4'h9, 8'h5A, 8'hA5, 4'h9, 8'd2, 4'd8},
    '{1'b0, 1'b1, 4'h3, 4'hE, 8'h1F, 8'h11, 4'h3, 8'd3, 4'd5}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int c0, chg0, expcyc;
    logic [7:0] mask;
    wr = 0; rd = 0; addr = 0; wdata = 0; nss_n = 1'b1; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 cs_n", 32'(cs_n), 32'hF);
    chk("R1 sck", 32'(sck), 32'h0);
    bus_read(ADDR_STAT_C, r);
    chk("R1 status", r, 32'h0);

    // R12 write while disabled
    bus_write(4'd1, mode_word(1'b0, 1'b0, 4'hE, 1'b1));
    bus_write(4'd3, 32'h0000_00A5);
    chk("R12 disabled cs_n", 32'(cs_n), 32'hF);
    bus_read(ADDR_STAT_C, r);
    chk("R12 disabled busy", r, 32'h0);

    bus_write(4'd8,  32'h0007_0001);
    bus_write(4'd9,  32'h0007_0002);
    bus_write(4'd10, 32'h0003_0000);
    bus_write(4'd11, 32'h0004_0003);
    bus_write(4'd0, 32'h1);
    bus_read(ADDR_STAT_C, r);
    chk("R11 enabled", r, 32'h8);

    // vector walk: R2 R3 R4 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      bus_write(4'd1, mode_word(VECS[v].vsel, VECS[v].dec, VECS[v].mpcs, 1'b1));
      cur_n = int'(VECS[v].en);
      cur_pat = VECS[v].pat;
      rise_base = rise_total;
      c0 = cyc_total; chg0 = chg_total;
      bus_write(4'd3, {12'h0, VECS[v].tpcs, 8'h0, VECS[v].data});
      wait_idle();
      mask = 8'((1 << cur_n) - 1);
      expcyc = int'(VECS[v].eh) * (2 * cur_n + 1);
      chk("R2/R3/R4/R5 select pattern", 32'(last_cs), 32'(VECS[v].ecs));
      chk("R6 select width", 32'(cyc_total - c0), 32'(expcyc));
      chk("R6 sck rises", 32'(rise_total - rise_base), 32'(cur_n));
      chk("R6 mosi data", 32'(mosi_cap & mask), 32'(VECS[v].data & mask));
      chk("R7 stable in transfer", 32'(chg_total - chg0), 32'h0);
      bus_read(ADDR_STAT_C, r);
      chk("R8 rx full set", r, 32'hC);
      bus_read(4'd4, r);
      chk("R8 rx data", 32'(r[7:0]), 32'(VECS[v].pat & mask));
      chk("R8 rx select", 32'(r[19:16]), 32'(VECS[v].ecs));
      bus_read(ADDR_STAT_C, r);
      chk("R8 rx full cleared", r, 32'h8);
    end

    // R4 / R5 code all ones starts nothing
    bus_write(4'd1, mode_word(1'b1, 1'b0, 4'hE, 1'b1));
    bus_write(4'd3, 32'h000F_0055);
    chk("R4 code F cs_n", 32'(cs_n), 32'hF);
    bus_read(ADDR_STAT_C, r);
    chk("R4 code F busy", r, 32'h8);
    bus_write(4'd1, mode_word(1'b1, 1'b1, 4'hE, 1'b1));
    bus_write(4'd3, 32'h000F_0055);
    bus_read(ADDR_STAT_C, r);
    chk("R5 code F busy", r, 32'h8);

    // R7 deferred MODE change, R12 write while busy
    bus_write(4'd1, mode_word(1'b0, 1'b0, 4'hE, 1'b1));
    cur_n = 8; cur_pat = 8'h00; rise_base = rise_total;
    c0 = cyc_total; chg0 = chg_total;
    bus_write(4'd3, 32'h0000_0042);
    bus_write(4'd1, mode_word(1'b0, 1'b0, 4'hD, 1'b1));
    bus_write(4'd3, 32'h0000_0099);
    wait_idle();
    chk("R7 old pattern kept", 32'(last_cs), 32'hE);
    chk("R7 no change mid transfer", 32'(chg_total - chg0), 32'h0);
    chk("R12 busy write dropped", 32'(cyc_total - c0), 32'd17);
    repeat (4) @(negedge clk);
    chk("R12 no second transfer", 32'(cs_n), 32'hF);
    bus_read(4'd4, r);
    rise_base = rise_total; c0 = cyc_total;
    bus_write(4'd3, 32'h0000_0011);
    wait_idle();
    chk("R7 next uses new code", 32'(last_cs), 32'hD);
    chk("R7 next uses CFG1", 32'(cyc_total - c0), 32'd34);
    bus_read(4'd4, r);

    // R10 / R11 mode fault
    rise_base = rise_total;
    bus_write(4'd3, 32'h0000_0033);
    repeat (3) @(negedge clk);
    nss_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R10 abort cs_n", 32'(cs_n), 32'hF);
    chk("R10 abort sck", 32'(sck), 32'h0);
    nss_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(ADDR_STAT_C, r);
    chk("R10 fault flag, disabled", r, 32'h1);
    bus_read(ADDR_STAT_C, r);
    chk("R11 cleared by read", r, 32'h0);
    bus_write(4'd3, 32'h0000_0077);
    chk("R12 after fault cs_n", 32'(cs_n), 32'hF);
    bus_read(ADDR_STAT_C, r);
    chk("R11 stays disabled", r, 32'h0);
    bus_write(4'd0, 32'h1);
    cur_n = 8; cur_pat = 8'h5C; rise_base = rise_total; c0 = cyc_total;
    bus_write(4'd3, 32'h0000_00C3);
    wait_idle();
    chk("R11 re-enabled transfer", 32'(cyc_total - c0), 32'd34);
    bus_read(4'd4, r);
    chk("R11 re-enabled rx", 32'(r[7:0]), 32'h5C);

    // R9 not master
    bus_write(4'd1, mode_word(1'b0, 1'b0, 4'hE, 1'b0));
    nss_n = 1'b0;
    repeat (6) @(negedge clk);
    bus_read(ADDR_STAT_C, r);
    chk("R9 nss ignored", r, 32'h8);
    bus_write(4'd3, 32'h0000_0044);
    chk("R9 no cs", 32'(cs_n), 32'hF);
    bus_read(ADDR_STAT_C, r);
    chk("R9 no busy", r, 32'h8);
    nss_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  localparam logic [3:0] ADDR_STAT_C = 4'd2;
endmodule